// File: doc/BRIEF.md
# Lightweight Memory-Mapped Serial Port

This block is a small asynchronous serial port placed on a simple word-addressed bus. Software sees four 32-bit registers: a receive window, a transmit window, a status word and a control word. Characters written to the transmit window are queued in a 16-deep buffer and shifted out on `txd`. Characters arriving on `rxd` are collected into a second 16-deep buffer, from which the receive window hands them out oldest first.

The line format is fixed at 8 data bits, least significant bit first, one stop bit and no parity. The bit rate is set at build time. A free-running divider makes an oversample tick every `OVS_DIV` clocks, and one bit lasts 16 ticks. Error conditions (receive overflow and a low stop bit) are latched in the status word until software reads it. A one-cycle interrupt pulse is produced on buffer events while interrupts are enabled.

Software drives the port by polling the status word or by reacting to the pulse. It writes the transmit window only while the full flag is clear, and it reads the receive window only while the valid flag is set. The control word flushes either buffer and sets or clears the interrupt enable.

Top module: `lite_uart`

## Requirements
- R1: The register is selected by `bus_addr[3:2]`: 0 is the receive window, 1 the transmit window, 2 status and 3 control. Writes to the receive window or the status word change nothing. Reads of the transmit window and the control word return 0.
- R2: The status word has these bits: bit0 receive buffer non-empty, bit1 receive buffer full, bit2 transmit buffer empty, bit3 transmit buffer full, bit4 interrupt enable, bit5 overrun, bit6 framing error, bit7 parity error (always 0). Bits 31:8 read 0.
- R3: After reset the status word reads 0x04, `irq` is 0 and `txd` is 1.
- R4: A write to the transmit window queues `bus_wdata[7:0]` when the buffer is not full and is dropped when it is full. The buffer holds 16 characters. Each character leaves as a low start bit, 8 data bits LSB first and a high stop bit, each bit 16 ticks long. `txd` is high while idle.
- R5: A read of the receive window returns the oldest stored character and removes it. A read while the buffer is empty returns 0 and removes nothing.
- R6: A character with a high stop bit is stored. If the receive buffer is already full, the character is discarded and the overrun bit is set.
- R7: A character whose stop bit is sampled low is discarded and sets the framing error bit. The receiver then waits for the line to return high before it looks for a new start bit.
- R8: The overrun and framing bits stay set until a status read. That read returns them set and clears them in the same cycle.
- R9: A control write with bit0 set flushes the transmit buffer, so the next status read shows bit2 = 1. Bit1 set flushes the receive buffer. Bit4 becomes the interrupt enable, so writing 0 disables interrupts.
- R10: While the interrupt enable is set, `irq` is high for one cycle after the receive buffer goes from empty to non-empty, or after the transmitter takes the last character from the transmit buffer. `irq` never rises while the enable is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte address within the 16-byte region |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access; side effects at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Assertions check on every cycle that `irq` follows only a set enable, that `txd` is high whenever the transmitter is idle, and that neither buffer count passes its depth. They also check that a control flush empties the transmit buffer on the next cycle, and that overrun and framing events latch their flags and keep them until a status read. Only the bench's scenarios can show the serial bit order and timing, the order of characters through the buffers, the dropping of a write to a full buffer, the discarding of overrun and badly framed characters, and the exact number of interrupt pulses for each kind of event.

// File: rtl/lite_uart.sv
module lite_uart #(
  parameter int OVS_DIV    = 2,
  parameter int FIFO_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        rxd,
  output logic        txd,
  output logic        irq
);

  localparam int AW   = $clog2(FIFO_DEPTH);
  localparam int CW   = AW + 1;
  localparam int DIVW = (OVS_DIV > 1) ? $clog2(OVS_DIV) : 1;
  localparam logic [CW-1:0]   FULL_CNT = CW'(FIFO_DEPTH);
  localparam logic [AW-1:0]   LAST_PTR = AW'(FIFO_DEPTH - 1);
  localparam logic [DIVW-1:0] DIV_LAST = DIVW'(OVS_DIV - 1);

  typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_t;
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAIT} rx_state_t;

  logic [1:0] sel;
  logic wr_tx, wr_ctl, rd_rx, rd_st;
  assign sel    = bus_addr[3:2];
  assign wr_tx  = bus_wr && sel == 2'd1;
  assign wr_ctl = bus_wr && sel == 2'd3;
  assign rd_rx  = bus_rd && sel == 2'd0;
  assign rd_st  = bus_rd && sel == 2'd2;

  logic flush_tx, flush_rx;
  assign flush_tx = wr_ctl && bus_wdata[0];
  assign flush_rx = wr_ctl && bus_wdata[1];

  logic unused_bits;
  assign unused_bits = ^{bus_wdata[31:8], bus_addr[1:0]};

  // oversample tick
  logic [DIVW-1:0] div_cnt;
  logic tick;
  assign tick = (div_cnt == DIV_LAST);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    div_cnt <= '0;
    else if (tick) div_cnt <= '0;
    else           div_cnt <= div_cnt + 1'b1;

  // transmit buffer
  logic [7:0]    tx_mem [FIFO_DEPTH];
  logic [AW-1:0] tx_wp, tx_rp;
  logic [CW-1:0] tx_cnt;
  logic tx_full, tx_empty, tx_push, tx_pop;
  tx_state_t tx_st;
  assign tx_full  = (tx_cnt == FULL_CNT);
  assign tx_empty = (tx_cnt == '0);
  assign tx_push  = wr_tx && !tx_full;
  assign tx_pop   = (tx_st == TX_IDLE) && !tx_empty;

  always_ff @(posedge clk)
    if (tx_push) tx_mem[tx_wp] <= bus_wdata[7:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (flush_tx) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= (tx_wp == LAST_PTR) ? '0 : tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= (tx_rp == LAST_PTR) ? '0 : tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end

  // transmitter
  logic [3:0] tx_tk;
  logic [2:0] tx_bit;
  logic [7:0] tx_sh;
  logic       txd_q;
  assign txd = txd_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_st <= TX_IDLE; tx_tk <= '0; tx_bit <= '0; tx_sh <= '0; txd_q <= 1'b1;
    end else if (tx_st == TX_IDLE) begin
      txd_q <= 1'b1;
      if (tx_pop) begin
        tx_sh <= tx_mem[tx_rp];
        tx_st <= TX_START;
        tx_tk <= '0;
        txd_q <= 1'b0;
      end
    end else if (tick) begin
      if (tx_tk == 4'd15) begin
        tx_tk <= '0;
        case (tx_st)
          TX_START: begin tx_st <= TX_DATA; tx_bit <= '0; txd_q <= tx_sh[0]; end
          TX_DATA:
            if (tx_bit == 3'd7) begin
              tx_st <= TX_STOP; txd_q <= 1'b1;
            end else begin
              tx_bit <= tx_bit + 1'b1;
              tx_sh  <= tx_sh >> 1;
              txd_q  <= tx_sh[1];
            end
          default: tx_st <= TX_IDLE;
        endcase
      end else begin
        tx_tk <= tx_tk + 1'b1;
      end
    end

  // receiver
  logic rx_s1, rx_s2;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin rx_s1 <= 1'b1; rx_s2 <= 1'b1; end
    else        begin rx_s1 <= rxd;  rx_s2 <= rx_s1; end

  rx_state_t  rx_st;
  logic [3:0] rx_tk;
  logic [2:0] rx_bit;
  logic [7:0] rx_sh;
  logic rx_done, rx_ferr;
  assign rx_done = tick && rx_st == RX_STOP && rx_tk == 4'd15 &&  rx_s2;
  assign rx_ferr = tick && rx_st == RX_STOP && rx_tk == 4'd15 && !rx_s2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_st <= RX_IDLE; rx_tk <= '0; rx_bit <= '0; rx_sh <= '0;
    end else if (tick) begin
      case (rx_st)
        RX_IDLE:
          if (!rx_s2) begin rx_st <= RX_START; rx_tk <= '0; end
        RX_START:
          if (rx_tk == 4'd7) begin
            rx_tk  <= '0;
            rx_bit <= '0;
            rx_st  <= rx_s2 ? RX_IDLE : RX_DATA;
          end else rx_tk <= rx_tk + 1'b1;
        RX_DATA:
          if (rx_tk == 4'd15) begin
            rx_tk <= '0;
            rx_sh <= {rx_s2, rx_sh[7:1]};
            if (rx_bit == 3'd7) rx_st <= RX_STOP;
            else                rx_bit <= rx_bit + 1'b1;
          end else rx_tk <= rx_tk + 1'b1;
        RX_STOP:
          if (rx_tk == 4'd15) begin
            rx_tk <= '0;
            rx_st <= rx_s2 ? RX_IDLE : RX_WAIT;
          end else rx_tk <= rx_tk + 1'b1;
        default:
          if (rx_s2) rx_st <= RX_IDLE;
      endcase
    end

  // receive buffer
  logic [7:0]    rx_mem [FIFO_DEPTH];
  logic [AW-1:0] rx_wp, rx_rp;
  logic [CW-1:0] rx_cnt;
  logic rx_full, rx_empty, rx_push, rx_pop;
  assign rx_full  = (rx_cnt == FULL_CNT);
  assign rx_empty = (rx_cnt == '0);
  assign rx_push  = rx_done && !rx_full;
  assign rx_pop   = rd_rx && !rx_empty;

  always_ff @(posedge clk)
    if (rx_push) rx_mem[rx_wp] <= rx_sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (flush_rx) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= (rx_wp == LAST_PTR) ? '0 : rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= (rx_rp == LAST_PTR) ? '0 : rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end

  // sticky flags, enable, interrupt
  logic ovr_q, fe_q, ie_q, irq_q;
  logic rx_evt, tx_evt;
  assign rx_evt = rx_push && rx_empty && !flush_rx;
  assign tx_evt = tx_pop && tx_cnt == CW'(1) && !flush_tx;
  assign irq    = irq_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ovr_q <= 1'b0; fe_q <= 1'b0; ie_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      ovr_q <= (rx_done && rx_full) || (ovr_q && !rd_st);
      fe_q  <= rx_ferr || (fe_q && !rd_st);
      if (wr_ctl) ie_q <= bus_wdata[4];
      irq_q <= ie_q && (rx_evt || tx_evt);
    end

  logic [7:0] status;
  assign status = {1'b0, fe_q, ovr_q, ie_q, tx_full, tx_empty, rx_full, !rx_empty};

  always_comb
    case (sel)
      2'd0:    bus_rdata = rx_empty ? 32'd0 : {24'd0, rx_mem[rx_rp]};
      2'd2:    bus_rdata = {24'd0, status};
      default: bus_rdata = 32'd0;
    endcase

  p_irq_needs_ie_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(ie_q));
  p_txd_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_st == TX_IDLE) |-> txd);
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= FULL_CNT) && (rx_cnt <= FULL_CNT));
  p_flush_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[3:2] == 2'd3 && bus_wdata[0]) |=> bus_rdata_tx_empty());
  p_overrun_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_full) |=> ovr_q);
  p_frame_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ferr |=> fe_q);
  p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovr_q || fe_q) && !rd_st) |=> (ovr_q || fe_q));

  function automatic logic bus_rdata_tx_empty();
    return tx_cnt == '0;
  endfunction

endmodule

// File: tb/lite_uart_bench.sv
`timescale 1ns/1ps
module lite_uart_bench;
  localparam int OVS = 2;
  localparam int BIT = 16 * OVS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic rxd = 1'b1, txd, irq;

  always #2.5 clk = ~clk;

  lite_uart #(.OVS_DIV(OVS), .FIFO_DEPTH(16)) u_lite_uart (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rxd(rxd), .txd(txd), .irq(irq));

  int checks = 0, fails = 0, irq_cnt = 0;
  logic [7:0] cap [32];
  int cap_n = 0;

  always @(negedge clk) if (irq) irq_cnt++;

  task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic expect_rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] d;
    rd(a, d);
    check(d == exp, tag, d, exp);
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop);
    rxd = 1'b0; repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd = b[i]; repeat (BIT) @(negedge clk); end
    rxd = stop; repeat (BIT) @(negedge clk);
    rxd = 1'b1; repeat (BIT) @(negedge clk);
  endtask

  task automatic capture(input int n);
    logic [7:0] b;
    cap_n = 0;
    for (int k = 0; k < n; k++) begin
      do @(negedge clk); while (txd !== 1'b0);
      repeat (BIT/2) @(negedge clk);
      check(txd == 1'b0, "R4 start bit", txd, 0);
      for (int i = 0; i < 8; i++) begin repeat (BIT) @(negedge clk); b[i] = txd; end
      repeat (BIT) @(negedge clk);
      check(txd == 1'b1, "R4 stop bit", txd, 1);
      cap[cap_n] = b; cap_n++;
    end
  endtask

  task automatic t_reset;
    expect_rd(4'h8, 32'h04, "R3 reset status");
    check(irq == 1'b0, "R3 irq idle", irq, 0);
    check(txd == 1'b1, "R3 txd idle", txd, 1);
    expect_rd(4'h0, 32'h0, "R5 empty read");
  endtask

  task automatic t_regmap;
    wr(4'hC, 32'h10);
    expect_rd(4'h8, 32'h14, "R9 enable readback");
    wr(4'h8, 32'hFF);
    wr(4'h0, 32'h55);
    expect_rd(4'h8, 32'h14, "R1 status write ignored");
    expect_rd(4'h4, 32'h0, "R1 tx window reads 0");
    expect_rd(4'hC, 32'h0, "R1 control reads 0");
    wr(4'hC, 32'h0);
    expect_rd(4'h8, 32'h04, "R2 enable cleared");
  endtask

  task automatic t_tx_basic;
    fork
      capture(3);
      begin wr(4'h4, 32'h123456A5); wr(4'h4, 32'h3C); wr(4'h4, 32'h81); end
    join
    check(cap[0] == 8'hA5, "R4 low byte only", cap[0], 8'hA5);
    check(cap[1] == 8'h3C, "R4 char 2", cap[1], 8'h3C);
    check(cap[2] == 8'h81, "R4 char 3", cap[2], 8'h81);
    repeat (BIT) @(negedge clk);
    expect_rd(4'h8, 32'h04, "R2 tx drained");
  endtask

  task automatic t_tx_full;
    bit seen_low;
    fork
      capture(17);
      begin
        for (int i = 0; i < 18; i++) wr(4'h4, 32'(i * 7 + 1));
        expect_rd(4'h8, 32'h08, "R2 tx full flag");
      end
    join
    for (int i = 0; i < 17; i++)
      check(cap[i] == 8'(i * 7 + 1), "R4 full order", cap[i], 8'(i * 7 + 1));
    seen_low = 1'b0;
    repeat (3 * BIT) begin @(negedge clk); if (txd == 1'b0) seen_low = 1'b1; end
    check(!seen_low, "R4 write when full dropped", seen_low, 0);
  endtask

  task automatic t_rx_basic;
    send_frame(8'h5A, 1'b1);
    send_frame(8'hC3, 1'b1);
    expect_rd(4'h8, 32'h05, "R2 rx valid");
    expect_rd(4'h0, 32'h5A, "R5 oldest first");
    expect_rd(4'h0, 32'hC3, "R5 second");
    expect_rd(4'h8, 32'h04, "R5 popped empty");
    expect_rd(4'h0, 32'h0, "R5 empty read 0");
  endtask

  task automatic t_overrun;
    for (int i = 0; i < 17; i++) send_frame(8'(8'h40 + i), 1'b1);
    expect_rd(4'h8, 32'h27, "R6 overrun flagged");
    expect_rd(4'h8, 32'h07, "R8 overrun cleared");
    for (int i = 0; i < 16; i++) expect_rd(4'h0, 32'(8'h40 + i), "R6 kept chars");
    expect_rd(4'h8, 32'h04, "R6 17th discarded");
  endtask

  task automatic t_frame;
    send_frame(8'h55, 1'b0);
    expect_rd(4'h8, 32'h44, "R7 framing flagged");
    expect_rd(4'h8, 32'h04, "R8 framing cleared");
    send_frame(8'h33, 1'b1);
    expect_rd(4'h0, 32'h33, "R7 recovers");
  endtask

  task automatic t_flush;
    send_frame(8'h11, 1'b1);
    send_frame(8'h22, 1'b1);
    wr(4'hC, 32'h02);
    expect_rd(4'h8, 32'h04, "R9 rx flush");
    wr(4'h4, 32'h01); wr(4'h4, 32'h02); wr(4'h4, 32'h03);
    expect_rd(4'h8, 32'h00, "R9 tx pending");
    wr(4'hC, 32'h01);
    expect_rd(4'h8, 32'h04, "R9 tx flush empty");
    repeat (12 * BIT) @(negedge clk);
  endtask

  task automatic t_irq;
    int base;
    logic [31:0] d;
    wr(4'hC, 32'h10);
    base = irq_cnt;
    send_frame(8'h77, 1'b1);
    check(irq_cnt == base + 1, "R10 rx irq", irq_cnt - base, 1);
    send_frame(8'h78, 1'b1);
    check(irq_cnt == base + 1, "R10 no irq when nonempty", irq_cnt - base, 1);
    rd(4'h0, d); rd(4'h0, d);
    wr(4'h4, 32'h99);
    repeat (5) @(negedge clk);
    check(irq_cnt == base + 2, "R10 tx empty irq", irq_cnt - base, 2);
    repeat (12 * BIT) @(negedge clk);
    wr(4'hC, 32'h0);
    base = irq_cnt;
    send_frame(8'h79, 1'b1);
    wr(4'h4, 32'h9A);
    repeat (12 * BIT) @(negedge clk);
    check(irq_cnt == base, "R10 silent when disabled", irq_cnt - base, 0);
    expect_rd(4'h0, 32'h79, "R10 rx data");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_regmap;
    t_tx_basic;
    t_tx_full;
    t_rx_basic;
    t_overrun;
    t_frame;
    t_flush;
    t_irq;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule